// File: doc/BRIEF.md
# Parallel LCD Command and Data Bus Writer

This block is a write-only master for an 8080-style parallel bus that feeds an LCD panel controller. An upstream sequencer hands it transfers over a valid/ready handshake. Each transfer is one of three kinds: a command code, a parameter byte, or a 16-bit pixel word. The block turns each transfer into a single strobed bus write. A select line marks command codes (low) apart from parameters and pixel data (high). Parameter bytes and command codes are zero-extended to the 16-bit bus.

The block also owns the panel reset pin and the backlight enable pin. After its own reset it turns the backlight on and runs a timed panel reset pulse. Only after that does it accept its first transfer. The pulse timing is derived from a clock-frequency parameter so that each phase lasts at least 100 us. The strobe low width and the post-strobe hold width are parameters counted in clock cycles. A busy flag and a one-cycle done pulse let the sequencer chain transfers back to back.

Top module: `lcd_bus_writer`

## Requirements
- R1: While `rst` is high, `lcd_cs_n`, `lcd_wr_n`, `lcd_rd_n` and `lcd_reset_n` are high, `lcd_db` is 16'hFFFF, `lcd_bl_en` is low, `req_ready` is low and `busy` is high.
- R2: `lcd_bl_en` goes high in the first cycle after reset. It stays high through the panel reset pulse and for as long as the block runs.
- R3: After reset, with N = ceil(CLK_HZ / 10000), `lcd_reset_n` stays high for at least N cycles. It is then low for exactly N cycles, and then high from that point on.
- R4: `req_ready` is low until the panel reset sequence has ended, and low while a transfer occupies the bus. A request held valid during that time causes no bus activity and is carried out exactly once when it is accepted.
- R5: `req_kind` 2'b00 is a command: `lcd_dc` is low and `lcd_db` is {8'h00, req_data[7:0]}.
- R6: `req_kind` 2'b01 is a parameter byte: `lcd_dc` is high and `lcd_db` is {8'h00, req_data[7:0]}. The upper input byte is ignored.
- R7: `req_kind` 2'b10 and 2'b11 are pixel words: `lcd_dc` is high and `lcd_db` equals all 16 bits of `req_data`.
- R8: For each transfer, `lcd_cs_n` is low with `lcd_dc` and `lcd_db` valid one cycle before `lcd_wr_n` falls. `lcd_wr_n` stays low for exactly STRB_LO_CYC cycles. `lcd_cs_n`, `lcd_dc` and `lcd_db` are then held for exactly STRB_HI_CYC cycles after `lcd_wr_n` rises, and after that `lcd_cs_n` returns high.
- R9: `lcd_rd_n` is high in every cycle.
- R10: `done` is a one-cycle pulse, once per transfer, in the first cycle after the hold phase. `busy` is high during the panel reset sequence and during every transfer.
- R11: `lcd_db` is 16'hFFFF from reset until the first transfer drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block can accept a transfer this cycle |
| req_kind | input | 2 | 00 command, 01 parameter byte, 1x pixel word |
| req_data | input | 16 | Command code or parameter in the low byte; pixel in all bits |
| busy | output | 1 | Panel reset sequence or transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer completes |
| lcd_cs_n | output | 1 | Bus chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, held high |
| lcd_dc | output | 1 | Low for a command code, high for parameters and pixels |
| lcd_db | output | 16 | Bus data |
| lcd_reset_n | output | 1 | Panel reset, active low |
| lcd_bl_en | output | 1 | Backlight enable, active high |

## Verification
The hardest situation to reach from the ports is a request that is already pending while the block cannot take it. The bench raises its first command together with the release of reset and holds it valid through the whole panel reset pulse. It then checks that the bus stays quiet and that the command appears on the bus exactly once. Later transfers are issued back to back, so each new request is waiting while the previous write is still in its strobe and hold phases. A monitor times every strobe and hold window against the parameters. It also compares each bus word against a queue of expected words that are formed from the request kind.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    localparam int unsigned BUS_W  = 16;
    localparam int unsigned CODE_W = 8;

    typedef enum logic [1:0] {
        KIND_CMD     = 2'b00,
        KIND_PARAM   = 2'b01,
        KIND_PIX     = 2'b10,
        KIND_PIX_ALT = 2'b11
    } kind_e;

    typedef struct packed {
        logic             dc;
        logic [BUS_W-1:0] word;
    } beat_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        POR_LEAD,
        POR_PULSE,
        POR_RUN
    } por_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // cycles needed to cover 100 us at the given clock rate
    function automatic int unsigned cycles_100us(input int unsigned hz);
        return ceil_div(hz, 10000);
    endfunction

    function automatic beat_t form_beat(input kind_e kind, input logic [BUS_W-1:0] data);
        beat_t b;
        case (kind)
            KIND_CMD: begin
                b.dc   = 1'b0;
                b.word = {{(BUS_W-CODE_W){1'b0}}, data[CODE_W-1:0]};
            end
            KIND_PARAM: begin
                b.dc   = 1'b1;
                b.word = {{(BUS_W-CODE_W){1'b0}}, data[CODE_W-1:0]};
            end
            default: begin
                b.dc   = 1'b1;
                b.word = data;
            end
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdw_por_seq.sv
module lcdw_por_seq
    import lcdw_pkg::*;
#(
    parameter int unsigned INTERVAL = 12500
) (
    input  logic clk,
    input  logic rst,
    output logic panel_rst_n,
    output logic bl_on,
    output logic seq_done
);

    localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    por_e          state_q;
    logic [CW-1:0] cnt_q;
    logic          rst_n_q;
    logic          bl_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= POR_LEAD;
            cnt_q   <= '0;
            rst_n_q <= 1'b1;
            bl_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            bl_q <= 1'b1;
            case (state_q)
                POR_LEAD: begin
                    if (cnt_q == LAST) begin
                        state_q <= POR_PULSE;
                        cnt_q   <= '0;
                        rst_n_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                POR_PULSE: begin
                    if (cnt_q == LAST) begin
                        state_q <= POR_RUN;
                        cnt_q   <= '0;
                        rst_n_q <= 1'b1;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    rst_n_q <= 1'b1;
                    done_q  <= 1'b1;
                end
            endcase
        end
    end

    assign panel_rst_n = rst_n_q;
    assign bl_on       = bl_q;
    assign seq_done    = done_q;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(done_q) |-> done_q); // R3
    AST_RUN_RESET_HIGH: assert property (@(posedge clk) disable iff (rst)
        done_q |-> rst_n_q); // R3
    AST_BL_STAYS_ON: assert property (@(posedge clk) disable iff (rst)
        $past(bl_q) |-> bl_q); // R2
    AST_PULSE_WITH_BL: assert property (@(posedge clk) disable iff (rst)
        !rst_n_q |-> bl_q); // R2

endmodule

// File: rtl/lcdw_bus_engine.sv
module lcdw_bus_engine
    import lcdw_pkg::*;
#(
    parameter int unsigned LO_CYC = 2,
    parameter int unsigned HI_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  beat_t            beat_in,
    output logic             idle,
    output logic             done_pulse,
    output logic             cs_n,
    output logic             wr_n,
    output logic             dc,
    output logic [BUS_W-1:0] bus
);

    localparam int unsigned MAXW = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int unsigned CW   = (MAXW > 1) ? $clog2(MAXW) : 1;
    localparam logic [CW-1:0] LO_LAST = CW'(LO_CYC - 1);
    localparam logic [CW-1:0] HI_LAST = CW'(HI_CYC - 1);

    phase_e        ph_q;
    logic [CW-1:0] cnt_q;
    beat_t         beat_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            beat_q <= '{dc: 1'b1, word: '1};
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        beat_q <= beat_in;
                        ph_q   <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    ph_q  <= PH_STROBE;
                    cnt_q <= '0;
                end
                PH_STROBE: begin
                    if (cnt_q == LO_LAST) begin
                        ph_q  <= PH_HOLD;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == HI_LAST) begin
                        ph_q   <= PH_IDLE;
                        cnt_q  <= '0;
                        done_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign idle       = (ph_q == PH_IDLE);
    assign done_pulse = done_q;
    assign cs_n       = (ph_q == PH_IDLE);
    assign wr_n       = (ph_q != PH_STROBE);
    assign dc         = beat_q.dc;
    assign bus        = beat_q.word;

    AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> !cs_n); // R8
    AST_START_SETUP: assert property (@(posedge clk) disable iff (rst)
        (start && idle) |=> (!cs_n && wr_n)); // R8
    AST_BEAT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> $stable(beat_q)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R10
    AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (cs_n && $past(!cs_n))); // R10

endmodule

// File: rtl/lcd_bus_writer.sv
module lcd_bus_writer
    import lcdw_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 125_000_000,
    parameter int unsigned STRB_LO_CYC = 2,
    parameter int unsigned STRB_HI_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic [15:0] req_data,
    output logic        busy,
    output logic        done,
    output logic        lcd_cs_n,
    output logic        lcd_wr_n,
    output logic        lcd_rd_n,
    output logic        lcd_dc,
    output logic [15:0] lcd_db,
    output logic        lcd_reset_n,
    output logic        lcd_bl_en
);

    localparam int unsigned RESET_CYC = cycles_100us(CLK_HZ);

    logic  por_done;
    logic  eng_idle;
    logic  accept;
    beat_t req_beat;

    lcdw_por_seq #(
        .INTERVAL (RESET_CYC)
    ) por_i (
        .clk         (clk),
        .rst         (rst),
        .panel_rst_n (lcd_reset_n),
        .bl_on       (lcd_bl_en),
        .seq_done    (por_done)
    );

    assign req_ready = por_done && eng_idle;
    assign accept    = req_valid && req_ready;
    assign req_beat  = form_beat(kind_e'(req_kind), req_data);

    lcdw_bus_engine #(
        .LO_CYC (STRB_LO_CYC),
        .HI_CYC (STRB_HI_CYC)
    ) eng_i (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .beat_in    (req_beat),
        .idle       (eng_idle),
        .done_pulse (done),
        .cs_n       (lcd_cs_n),
        .wr_n       (lcd_wr_n),
        .dc         (lcd_dc),
        .bus        (lcd_db)
    );

    assign lcd_rd_n = 1'b1;
    assign busy     = !req_ready;

    AST_QUIET_DURING_POR: assert property (@(posedge clk) disable iff (rst)
        !por_done |-> (lcd_cs_n && lcd_wr_n)); // R4
    AST_BUS_IDLE_BEFORE_POR: assert property (@(posedge clk) disable iff (rst)
        !por_done |-> (lcd_db == 16'hFFFF)); // R11
    AST_BUSY_ON_CS: assert property (@(posedge clk) disable iff (rst)
        !lcd_cs_n |-> busy); // R10

endmodule

// File: tb/lcd_bus_writer_tb_top.sv
module lcd_bus_writer_tb_top;

    localparam int unsigned CLK_HZ = 200_000;
    localparam int unsigned N      = 20;
    localparam int unsigned LO     = 3;
    localparam int unsigned HI     = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_kind;
    logic [15:0] req_data;
    logic        busy, done;
    logic        lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_dc;
    logic [15:0] lcd_db;
    logic        lcd_reset_n, lcd_bl_en;

    always #4 clk = ~clk;

    lcd_bus_writer #(
        .CLK_HZ      (CLK_HZ),
        .STRB_LO_CYC (LO),
        .STRB_HI_CYC (HI)
    ) dut_i (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_kind (req_kind), .req_data (req_data),
        .busy (busy), .done (done),
        .lcd_cs_n (lcd_cs_n), .lcd_wr_n (lcd_wr_n), .lcd_rd_n (lcd_rd_n),
        .lcd_dc (lcd_dc), .lcd_db (lcd_db),
        .lcd_reset_n (lcd_reset_n), .lcd_bl_en (lcd_bl_en)
    );

    int checks = 0;
    int fails  = 0;
    int sent   = 0;
    logic [18:0] exp_q[$];   // {kind, dc, word}

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [15:0] d);
        logic        e_dc;
        logic [15:0] e_w;
        e_dc = (k != 2'b00);
        e_w  = (k[1] == 1'b0) ? {8'h00, d[7:0]} : d;
        exp_q.push_back({k, e_dc, e_w});
        sent++;
        req_kind  = k;
        req_data  = d;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor state
    logic        prev_wr = 1'b1, prev_cs = 1'b1, prev_dc = 1'b1;
    logic [15:0] prev_db = 16'hFFFF, hold_word = 16'h0;
    int lo_cnt = 0, hold_cnt = 0, done_cnt = 0;
    bit in_hold = 0, por_seen = 0;
    int rd_bad = 0, rdy_bad = 0, early_bus = 0, busy_bad = 0, hold_bad = 0, bl_bad = 0, relow = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (lcd_rd_n !== 1'b1) rd_bad++;
            if (!lcd_cs_n && req_ready) rdy_bad++;
            if (!lcd_cs_n && !busy) busy_bad++;
            if (!por_seen && (!lcd_cs_n || !lcd_wr_n)) early_bus++;
            if ((!lcd_reset_n || por_seen) && !lcd_bl_en) bl_bad++;
            if (por_seen && !lcd_reset_n) relow++;
            if (req_ready && !por_seen) begin
                por_seen = 1;
                chk(lcd_db == 16'hFFFF, "R11", "idle bus before first write", lcd_db, 16'hFFFF);
            end
            if (done) done_cnt++;
            if (prev_wr && !lcd_wr_n) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5", "unexpected write", {15'h0, lcd_dc, lcd_db}, 0);
                end else begin
                    logic [18:0] e;
                    string tag;
                    e = exp_q.pop_front();
                    tag = (e[18:17] == 2'b00) ? "R5" : (e[18:17] == 2'b01) ? "R6" : "R7";
                    chk({lcd_dc, lcd_db} == e[16:0], tag, "dc and bus word",
                        {15'h0, lcd_dc, lcd_db}, {15'h0, e[16:0]});
                end
                chk(!prev_cs && prev_db == lcd_db && prev_dc == lcd_dc, "R8", "setup cycle",
                    {prev_cs, prev_dc, prev_db}, {2'b00, lcd_dc, lcd_db});
                lo_cnt = 1;
            end else if (!lcd_wr_n) begin
                lo_cnt++;
            end
            if (!prev_wr && lcd_wr_n) begin
                chk(lo_cnt == LO, "R8", "strobe low width", lo_cnt, LO);
                hold_cnt  = 0;
                in_hold   = 1;
                hold_word = prev_db;
            end
            if (in_hold) begin
                if (!lcd_cs_n) begin
                    hold_cnt++;
                    if (lcd_db !== hold_word) hold_bad++;
                end else begin
                    chk(hold_cnt == HI, "R8", "hold width", hold_cnt, HI);
                    chk(done == 1'b1, "R10", "done after hold", done, 1);
                    in_hold = 0;
                end
            end
            prev_wr = lcd_wr_n;
            prev_cs = lcd_cs_n;
            prev_dc = lcd_dc;
            prev_db = lcd_db;
        end
    end

    // panel reset pulse timing
    initial begin : por_meas
        int hi, lo;
        hi = 0;
        lo = 0;
        wait (rst === 1'b1);
        wait (rst === 1'b0);
        while (lcd_reset_n) begin hi++; @(negedge clk); end
        while (!lcd_reset_n) begin lo++; @(negedge clk); end
        chk(hi >= N, "R3", "reset lead high cycles", hi, N);
        chk(lo == N, "R3", "reset pulse low cycles", lo, N);
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        rst       = 1'b1;
        req_valid = 1'b0;
        req_kind  = 2'b00;
        req_data  = 16'h0;
        repeat (3) @(negedge clk);
        chk(lcd_cs_n && lcd_wr_n && lcd_rd_n && lcd_reset_n, "R1", "strobes and reset idle",
            {lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_reset_n}, 4'hF);
        chk(lcd_db == 16'hFFFF, "R1", "bus all ones", lcd_db, 16'hFFFF);
        chk(!lcd_bl_en && !req_ready && busy, "R1", "bl ready busy",
            {lcd_bl_en, req_ready, busy}, 3'b001);
        rst = 1'b0;
        // command pending through the whole panel reset sequence (R4)
        send(2'b00, 16'h37E2);
        chk(busy == 1'b1, "R10", "busy during transfer", busy, 1);
        send(2'b01, 16'hBE7F);
        send(2'b01, 16'h0001);
        send(2'b00, 16'hFF2C);
        send(2'b10, 16'hA5C3);
        send(2'b11, 16'h5A3C);
        send(2'b10, 16'h0000);
        send(2'b10, 16'hFFFF);
        send(2'b00, 16'h0029);
        send(2'b01, 16'h12FF);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "every request reached the bus", exp_q.size(), 0);
        chk(done_cnt == sent, "R10", "done pulses per transfer", done_cnt, sent);
        chk(rd_bad == 0, "R9", "read strobe high", rd_bad, 0);
        chk(rdy_bad == 0, "R4", "ready low during transfer", rdy_bad, 0);
        chk(early_bus == 0, "R4", "no bus activity before ready", early_bus, 0);
        chk(busy_bad == 0, "R10", "busy during transfer", busy_bad, 0);
        chk(hold_bad == 0, "R8", "data held after strobe", hold_bad, 0);
        chk(bl_bad == 0, "R2", "backlight stays on", bl_bad, 0);
        chk(relow == 0, "R3", "reset stays released", relow, 0);
        chk(lcd_bl_en == 1'b1, "R2", "backlight at end", lcd_bl_en, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule